// File: doc/BRIEF.md
# Ring Interrupt Status Controller

This block records completion events from the transmit and receive rings of a DMA host interface and presents them to software as memory-mapped status words. Each hop owns three event kinds: transmit done, receive done and receive overflow. An event latches a sticky bit in a packed status vector, and the first time that bit goes from idle to pending the block drives a one-cycle pulse on that ring's interrupt output.

Software picks one of two ways to retire pending bits through a control register. In clear-on-read mode, reading a status word returns it and empties the whole word, so an event that shares the word with the one being serviced is dropped. In per-bit mode, reads leave the status alone and software writes a 1 to the matching position of a separate clear window, so a receive completion stays pending while the transmit completion next to it is retired. Once a pulse has been raised, no further pulse is issued until software has read every status word.

Top module: `ring_irq_status`

## Requirements
- R1: With H hops, event kind k (0 = transmit, 1 = receive, 2 = receive overflow) on hop h sets flat bit index k*H + h. Flat bit i sits in status word i/32 at bit position i%32. There are (31 + 3*H)/32 status words, and word w is read at offset 0x37800 + 4*w.
- R2: A read request is answered on `bus_rdata` in the cycle after the edge that samples it, and it returns the word's contents from before that edge.
- R3: The mode register at offset 0x39864 keeps only bit 2 (clear-on-read enable) and bit 17 (automatic clear disable), reads back those two bits with every other bit zero, and clear-on-read is in force only when bit 2 is 1 and bit 17 is 0.
- R4: In clear-on-read mode, a read of a status word clears every bit of that word, including bits that software has not serviced.
- R5: Outside clear-on-read mode, a write to offset 0x37808 + 4*w clears exactly the bits of status word w where the write data holds a 1, and every other pending bit stays set. In clear-on-read mode, writes to the clear window have no effect.
- R6: Outside clear-on-read mode, a status read leaves every status bit unchanged.
- R7: An event that arrives in the same cycle as a read or a clear write aimed at its bit wins, and the bit stays pending.
- R8: An event that sets an idle bit while pulses are armed drives `irq_pulse` at that bit's flat index high for exactly one cycle, in the cycle after the event. An event for a bit that is already set produces no pulse.
- R9: After any pulse, pulses are disarmed. They re-arm after every status word has been read at least once since that pulse. An event sampled at the same edge as the read that completes the set still produces no pulse.
- R10: Reset clears all status bits and both mode bits, and leaves pulses armed.
- R11: Reads of any offset outside the status words and the mode register return zero. Writes outside the clear window and the mode register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tx | input | HOP_COUNT | Transmit done, one bit per hop, one cycle per event |
| ev_rx | input | HOP_COUNT | Receive done, one bit per hop |
| ev_ovf | input | HOP_COUNT | Receive overflow, one bit per hop |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_pulse | output | 3*HOP_COUNT | Per-ring interrupt pulse, indexed by flat bit |

## Verification
Every result is due one edge after its stimulus. A read sampled at edge n shows its data after edge n and clears its bits at that same edge, an event sampled at edge n sets its status bit and pulses at edge n, and a mode or clear write takes effect at the edge that samples it. The driver changes inputs on falling edges. The read monitor pairs each read it sees at a rising edge with the next falling edge and compares it against the queued expectation, and pulse checks are made at the falling edge right after the event edge. The case where transmit and receive complete together is run in both modes: in per-bit mode the receive bit must survive the transmit clear, and in clear-on-read mode it must be lost.

// File: rtl/ring_irq_pkg.sv
package ring_irq_pkg;
  localparam int WORD_W      = 32;
  localparam int STATUS_BASE = 32'h0003_7800;
  localparam int CLEAR_BASE  = 32'h0003_7808;
  localparam int MODE_ADDR   = 32'h0003_9864;
  localparam int MODE_COR_BIT   = 2;
  localparam int MODE_NOCLR_BIT = 17;

  typedef enum logic [1:0] {
    KIND_TX  = 2'd0,
    KIND_RX  = 2'd1,
    KIND_OVF = 2'd2
  } ev_kind_e;

  function automatic int status_words(input int hops);
    return (31 + 3 * hops) / 32;
  endfunction

  function automatic int flat_index(input ev_kind_e kind, input int hop, input int hops);
    return int'(kind) * hops + hop;
  endfunction

  function automatic int word_offset(input int base, input int word);
    return base + 4 * word;
  endfunction

  function automatic logic cor_active(input logic cor_en, input logic noclr);
    return cor_en & ~noclr;
  endfunction
endpackage

// File: rtl/ris_bus_decode.sv
module ris_bus_decode
  import ring_irq_pkg::*;
#(
  parameter int NW     = 2,
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [NW-1:0]     sts_rd_hit,
  output logic [NW-1:0]     clr_wr_hit,
  output logic              mode_rd_hit,
  output logic              mode_wr_hit
);
  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(word_offset(STATUS_BASE, w));
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(word_offset(CLEAR_BASE, w));
    assign sts_rd_hit[w] = rd && (addr == STS_A);
    assign clr_wr_hit[w] = wr && (addr == CLR_A);
  end

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  assign mode_rd_hit = rd && (addr == MODE_A);
  assign mode_wr_hit = wr && (addr == MODE_A);
endmodule

// File: rtl/ris_status_word.sv
module ris_status_word #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] word_o,
  output logic [W-1:0] fresh_o
);
  logic [W-1:0] word_q;
  logic [W-1:0] drop;

  assign drop    = rd_clr_i ? {W{1'b1}} : w1c_i;
  assign fresh_o = set_i & ~word_q;
  assign word_o  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= (word_q & ~drop) | set_i;
  end
endmodule

// File: rtl/ris_irq_gate.sv
module ris_irq_gate #(
  parameter int NW = 2,
  parameter int NB = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] fresh_i,
  input  logic [NW-1:0] rd_hit_i,
  output logic [NB-1:0] pulse_o,
  output logic          armed_o
);
  logic          armed_q;
  logic [NW-1:0] seen_q;
  logic [NW-1:0] seen_nx;
  logic          fire;

  assign fire    = armed_q && (|fresh_i);
  assign seen_nx = seen_q | rd_hit_i;
  assign armed_o = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      seen_q  <= '0;
      pulse_o <= '0;
    end else begin
      pulse_o <= fire ? fresh_i : '0;
      if (fire) begin
        armed_q <= 1'b0;
        seen_q  <= '0;
      end else if (!armed_q && (&seen_nx)) begin
        armed_q <= 1'b1;
        seen_q  <= '0;
      end else begin
        seen_q  <= seen_nx;
      end
    end
  end
endmodule

// File: rtl/ring_irq_status.sv
module ring_irq_status
  import ring_irq_pkg::*;
#(
  parameter int HOP_COUNT = 12,
  parameter int ADDR_W    = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HOP_COUNT-1:0]   ev_tx,
  input  logic [HOP_COUNT-1:0]   ev_rx,
  input  logic [HOP_COUNT-1:0]   ev_ovf,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  output logic [3*HOP_COUNT-1:0] irq_pulse
);
  localparam int NB = 3 * HOP_COUNT;
  localparam int NW = status_words(HOP_COUNT);
  localparam int FW = NW * WORD_W;

  logic [NW-1:0]     sts_rd_hit;
  logic [NW-1:0]     clr_wr_hit;
  logic              mode_rd_hit;
  logic              mode_wr_hit;
  logic              mode_cor_q;
  logic              mode_noclr_q;
  logic              cor_on;
  logic [FW-1:0]     set_full;
  logic [FW-1:0]     sts_full;
  logic [FW-1:0]     fresh_full;
  logic [NB-1:0]     sts_flat;
  logic [NB-1:0]     set_flat;
  logic              armed;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] mode_view;

  ris_bus_decode #(.NW(NW), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .sts_rd_hit(sts_rd_hit), .clr_wr_hit(clr_wr_hit),
    .mode_rd_hit(mode_rd_hit), .mode_wr_hit(mode_wr_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cor_q   <= 1'b0;
      mode_noclr_q <= 1'b0;
    end else if (mode_wr_hit) begin
      mode_cor_q   <= bus_wdata[MODE_COR_BIT];
      mode_noclr_q <= bus_wdata[MODE_NOCLR_BIT];
    end
  end

  assign cor_on = cor_active(mode_cor_q, mode_noclr_q);

  always_comb begin
    mode_view = '0;
    mode_view[MODE_COR_BIT]   = mode_cor_q;
    mode_view[MODE_NOCLR_BIT] = mode_noclr_q;
  end

  assign set_flat = {ev_ovf, ev_rx, ev_tx};

  always_comb begin
    set_full = '0;
    set_full[NB-1:0] = set_flat;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W-1:0] w1c;
    assign w1c = (!cor_on && clr_wr_hit[w]) ? bus_wdata : '0;
    ris_status_word #(.W(WORD_W)) u_word (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_full[w*WORD_W +: WORD_W]),
      .rd_clr_i(cor_on && sts_rd_hit[w]),
      .w1c_i(w1c),
      .word_o(sts_full[w*WORD_W +: WORD_W]),
      .fresh_o(fresh_full[w*WORD_W +: WORD_W])
    );
  end

  assign sts_flat = sts_full[NB-1:0];

  ris_irq_gate #(.NW(NW), .NB(NB)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .fresh_i(fresh_full[NB-1:0]),
    .rd_hit_i(sts_rd_hit),
    .pulse_o(irq_pulse),
    .armed_o(armed)
  );

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++)
      if (sts_rd_hit[w]) rd_mux = rd_mux | sts_full[w*WORD_W +: WORD_W];
    if (mode_rd_hit) rd_mux = rd_mux | mode_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ring_irq_status_chk.sv
module ring_irq_status_chk #(
  parameter int NB = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] irq_pulse,
  input logic [NB-1:0] sts_flat,
  input logic [NB-1:0] set_flat,
  input logic          cor_on,
  input logic          bus_wr,
  input logic          armed
);
  assert_pulse_marks_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~sts_flat) == '0);

  assert_pulse_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> ((irq_pulse & $past(sts_flat)) == '0));

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |=> ((irq_pulse & $past(irq_pulse)) == '0));

  assert_pulse_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |=> (!armed && irq_pulse == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_flat) |=> (($past(set_flat) & ~sts_flat) == '0));

  assert_read_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cor_on && !bus_wr) |=> (($past(sts_flat) & ~sts_flat) == '0));
endmodule

bind ring_irq_status ring_irq_status_chk #(.NB(3 * HOP_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .sts_flat(sts_flat),
  .set_flat(set_flat), .cor_on(cor_on), .bus_wr(bus_wr), .armed(armed)
);

// File: tb/ring_irq_status_bench.sv
module ring_irq_status_bench;
  localparam int H  = 12;
  localparam int NB = 3 * H;
  localparam int AW = 20;
  localparam logic [AW-1:0] A_STS0 = 20'h37800;
  localparam logic [AW-1:0] A_STS1 = 20'h37804;
  localparam logic [AW-1:0] A_CLR0 = 20'h37808;
  localparam logic [AW-1:0] A_CLR1 = 20'h3780C;
  localparam logic [AW-1:0] A_MODE = 20'h39864;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [H-1:0]  ev_tx = '0, ev_rx = '0, ev_ovf = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NB-1:0] irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ring_irq_status #(.HOP_COUNT(H), .ADDR_W(AW)) u_ring_irq_status (
    .clk(clk), .rst_n(rst_n), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  // flat index per R1: kind*H + hop
  function automatic logic [63:0] fb(input int kind, input int hop);
    return 64'd1 << (kind * H + hop);
  endfunction

  function automatic logic [31:0] wd(input logic [63:0] v, input int w);
    return v[w*32 +: 32];
  endfunction

  function automatic logic [H-1:0] hb(input int hop);
    return H'(1) << hop;
  endfunction

  task automatic check32(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one edge after each sampled read
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: unexpected read, actual %h expected none", bus_rdata);
        end else begin
          check32(64'(bus_rdata), 64'(exp_q.pop_front()), tag_q.pop_front());
        end
      end
    end
  end

  task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic fire(input logic [H-1:0] t, input logic [H-1:0] r, input logic [H-1:0] o,
                      input logic [63:0] exp_irq, input string tag);
    @(negedge clk);
    ev_tx = t; ev_rx = r; ev_ovf = o;
    @(negedge clk);
    check32(64'(irq_pulse), exp_irq, tag);
    ev_tx = '0; ev_rx = '0; ev_ovf = '0;
  endtask

  task automatic fire_with_clear(input logic [H-1:0] t, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    ev_tx = t; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    ev_tx = '0; bus_wr = 1'b0;
  endtask

  task automatic fire_with_read(input logic [H-1:0] t, input logic [AW-1:0] a,
                                input logic [31:0] exp, input string tag);
    @(negedge clk);
    ev_tx = t; bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    ev_tx = '0; bus_rd = 1'b0;
  endtask

  initial begin
    logic [63:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    bus_read(A_STS0, 32'h0, "R10 status word 0 after reset");
    bus_read(A_STS1, 32'h0, "R10 status word 1 after reset");
    bus_read(A_MODE, 32'h0, "R10 mode after reset");

    // per-bit mode: bit 17 set
    bus_write(A_MODE, 32'h0002_0000);
    bus_read(A_MODE, 32'h0002_0000, "R3 mode readback per-bit");
    st = fb(0, 3) | fb(1, 3);
    fire(hb(3), hb(3), '0, st, "R8 R1 tx3 and rx3 pulse together");
    bus_read(A_STS0, wd(st, 0), "R1 R6 both pending, read keeps");
    bus_write(A_CLR0, 32'd1 << 3);
    st = fb(1, 3);
    bus_read(A_STS0, wd(st, 0), "R5 rx survives tx clear");
    bus_read(A_STS1, 32'h0, "R9 last word read re-arms");

    fire('0, hb(3), '0, 64'h0, "R8 already pending gives no pulse");
    fire(hb(3), '0, '0, fb(0, 3), "R8 idle bit pulses when armed");
    st |= fb(0, 3);
    fire(hb(5), '0, '0, 64'h0, "R9 disarmed after pulse");
    st |= fb(0, 5);
    bus_read(A_STS0, wd(st, 0), "R6 word 0 during disarm");
    fire(hb(6), '0, '0, 64'h0, "R9 one word read is not enough");
    st |= fb(0, 6);
    bus_read(A_STS1, 32'h0, "R9 word 1 completes re-arm");
    fire('0, '0, hb(11), fb(2, 11), "R1 R8 overflow hop 11 in word 1");
    st |= fb(2, 11);

    // R11 unmapped access
    bus_read(20'h37900, 32'h0, "R11 unmapped read");
    bus_write(20'h37904, 32'hFFFF_FFFF);
    bus_write(A_STS0, 32'hFFFF_FFFF);
    bus_read(A_STS0, wd(st, 0), "R11 writes outside clear window ignored");
    bus_read(A_STS1, wd(st, 1), "R1 overflow hop 11 at word 1 bit 3");

    // R7 set wins over clear write
    fire_with_clear(hb(5), A_CLR0, 32'd1 << 5);
    bus_read(A_STS0, wd(st, 0), "R7 set beats clear write");
    bus_write(A_CLR0, 32'hFFFF_FFFF);
    bus_write(A_CLR1, 32'hFFFF_FFFF);
    bus_read(A_STS0, 32'h0, "R5 full clear word 0");
    bus_read(A_STS1, 32'h0, "R5 full clear word 1");

    // clear-on-read mode
    bus_write(A_MODE, 32'hFFFF_FFFF);
    bus_read(A_MODE, 32'h0002_0004, "R3 only mode bits kept");
    bus_write(A_MODE, 32'h0000_0004);
    bus_read(A_MODE, 32'h0000_0004, "R3 clear-on-read readback");
    st = fb(0, 3) | fb(1, 3);
    fire(hb(3), hb(3), '0, st, "R8 pulse in clear-on-read mode");
    bus_read(A_STS0, wd(st, 0), "R4 read returns both");
    bus_read(A_STS0, 32'h0, "R4 rx lost by read of tx");
    fire(hb(7), '0, '0, 64'h0, "R9 disarmed in clear-on-read");
    bus_write(A_CLR0, 32'd1 << 7);
    bus_read(A_STS0, 32'd1 << 7, "R5 clear write ignored in clear-on-read");
    bus_read(A_STS0, 32'h0, "R4 cleared by read");
    fire_with_read(hb(8), A_STS0, 32'h0, "R2 read returns pre-edge value");
    bus_read(A_STS0, 32'd1 << 8, "R7 set beats clear-on-read");

    // R10 reset mid-run
    fire(hb(1), '0, '0, 64'h0, "R9 still disarmed");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(A_MODE, 32'h0, "R10 mode cleared by reset");
    bus_read(A_STS0, 32'h0, "R10 status cleared by reset");
    fire(hb(2), '0, '0, fb(0, 2), "R10 armed after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule